// File: doc/BRIEF.md
# Packet Byte Register with Parity

This block is the byte-wide datapath stage that sits between a router's input port and its output buffers. A packet arrives as one header byte, then between 1 and 63 payload bytes, then one check byte, each 8 bits wide. The header carries the destination address and the payload length. A separate controller drives the strobes that say what the byte on `din` is. The block passes every accepted byte to `dout` one clock later. It also keeps a running XOR over the header and payload bytes and compares that value with the check byte.

When the downstream buffer reports full, a payload byte cannot be passed on. The block parks it in a one-byte holding register and keeps `dout` frozen while the controller waits. When the controller signals that space has opened, the parked byte is driven to `dout` before any new byte is taken. Inputs are expected to change on the falling clock edge; all state updates on the rising edge.

Top module: `pkt_byte_reg`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next cycle shows `dout` = 0, `par_done` = 0 and `par_err` = 0.
- R2: With `hdr_strobe` and `addr_hit` both high, `dout` shows `din` the next cycle, the running parity restarts from that byte, and `par_err` is cleared.
- R3: `hdr_strobe` without `addr_hit`, with no other strobe active, leaves `dout` unchanged.
- R4: With `data_strobe` and `pkt_valid` high and `buf_full` low, `dout` shows `din` the next cycle, and the byte is XORed into the running parity.
- R5: `data_strobe` with `pkt_valid` low, with no other strobe active, leaves `dout` and the running parity unchanged.
- R6: With `data_strobe` and `pkt_valid` high and `buf_full` high, `dout` is unchanged and the byte is stored in the holding register. The byte still joins the running parity.
- R7: With `wait_strobe` and `buf_full` high, and neither the header, check nor resume strobe active, `dout` is unchanged.
- R8: `resume_strobe` drives the held byte onto `dout` the next cycle, and the running parity does not change.
- R9: `chk_strobe` drives `din` onto `dout` the next cycle and raises `par_done` for that cycle only. `par_done` is never high unless `chk_strobe` was high at the previous edge.
- R10: At a `chk_strobe` edge, `par_err` becomes 1 if the running parity differs from `din`.
- R11: Once set, `par_err` stays high until the next header load (R2) or reset.
- R12: Strobe priority, highest first: header load, check byte, resume, wait, payload. Only the highest active operation takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | DATA_W | Incoming byte |
| pkt_valid | input | 1 | Source has a payload byte on `din` |
| hdr_strobe | input | 1 | Controller is loading the first byte |
| addr_hit | input | 1 | Destination address decoded for this packet |
| data_strobe | input | 1 | Controller is loading payload |
| wait_strobe | input | 1 | Controller is waiting on a full buffer |
| resume_strobe | input | 1 | Controller resumes after full; replay held byte |
| chk_strobe | input | 1 | `din` carries the packet's check byte |
| buf_full | input | 1 | Downstream buffer cannot take a byte |
| dout | output | DATA_W | Registered byte toward the buffer |
| par_done | output | 1 | One-cycle pulse after the check byte |
| par_err | output | 1 | Sticky parity mismatch flag |

## Verification
The assertions check on every cycle that the header load shows its byte and clears the error, and that `dout` stays frozen during a full-buffer wait and for an unqualified payload strobe. They also check that `par_done` only follows a check strobe and that the error flag is sticky. Only the bench's scenarios can show that the parity value itself is right across packets of random length, including stalled bytes that count once. They likewise show that a replay returns exactly the parked byte and that a 63-byte packet and a corrupted check byte give the expected flag.

// File: rtl/pbr_pkg.sv
// Shared definitions for the packet byte register.
// Assumes one operation per cycle, chosen by fixed strobe priority.
package pbr_pkg;
    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_HDR    = 3'd1,
        OP_PAY    = 3'd2,
        OP_STASH  = 3'd3,
        OP_WAIT   = 3'd4,
        OP_REPLAY = 3'd5,
        OP_CHK    = 3'd6
    } pbr_op_e;
endpackage

// File: rtl/pbr_decode.sv
// Strobe decoder: turns the controller strobes into one operation.
// Priority: header, check byte, resume, wait, payload (stalled or not).
// Assumes the strobes are stable around the rising edge.
module pbr_decode
    import pbr_pkg::*;
(
    input  logic    hdr_strobe,
    input  logic    addr_hit,
    input  logic    data_strobe,
    input  logic    pkt_valid,
    input  logic    wait_strobe,
    input  logic    resume_strobe,
    input  logic    chk_strobe,
    input  logic    buf_full,
    output pbr_op_e op
);
    // Pick the single operation for this cycle
    always_comb begin
        if (hdr_strobe && addr_hit)        op = OP_HDR;
        else if (chk_strobe)               op = OP_CHK;
        else if (resume_strobe)            op = OP_REPLAY;
        else if (wait_strobe)              op = OP_WAIT;
        else if (data_strobe && pkt_valid) op = buf_full ? OP_STASH : OP_PAY;
        else                               op = OP_IDLE;
    end
endmodule

// File: rtl/pbr_parity.sv
// Running XOR parity over header and payload, compared with the check byte.
// Assumes a header load precedes every packet; it restarts the sum.
module pbr_parity
    import pbr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pbr_op_e           op,
    input  logic [DATA_W-1:0] din,
    output logic              par_done,
    output logic              par_err
);
    logic [DATA_W-1:0] acc_q;

    // Accumulate parity: restart on header, fold in accepted payload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            case (op)
                OP_HDR:           acc_q <= din;
                OP_PAY, OP_STASH: acc_q <= acc_q ^ din;
                default:          acc_q <= acc_q;
            endcase
        end
    end

    // Done pulse and sticky mismatch flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_done <= 1'b0;
            par_err  <= 1'b0;
        end else begin
            par_done <= (op == OP_CHK);
            if (op == OP_HDR)
                par_err <= 1'b0;
            else if (op == OP_CHK)
                par_err <= par_err | (acc_q != din);
        end
    end
endmodule

// File: rtl/pbr_datapath.sv
// Output byte register with a one-byte holding slot for full-buffer stalls.
// Assumes the controller replays a held byte before the next payload.
module pbr_datapath
    import pbr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pbr_op_e           op,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] hold_q;

    // Park a payload byte that arrived while the buffer was full
    always_ff @(posedge clk) begin
        if (!rst_n)               hold_q <= '0;
        else if (op == OP_STASH)  hold_q <= din;
    end

    // Drive the output byte according to the operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else begin
            case (op)
                OP_HDR, OP_PAY, OP_CHK: dout <= din;
                OP_REPLAY:              dout <= hold_q;
                default:                dout <= dout;
            endcase
        end
    end
endmodule

// File: rtl/pkt_byte_reg.sv
// Top of the packet byte register: decode, datapath and parity checker.
// Assumes inputs change on the falling edge and are sampled on the rising edge.
module pkt_byte_reg
    import pbr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic              pkt_valid,
    input  logic              hdr_strobe,
    input  logic              addr_hit,
    input  logic              data_strobe,
    input  logic              wait_strobe,
    input  logic              resume_strobe,
    input  logic              chk_strobe,
    input  logic              buf_full,
    output logic [DATA_W-1:0] dout,
    output logic              par_done,
    output logic              par_err
);
    pbr_op_e op;

    pbr_decode u_decode (
        .hdr_strobe    (hdr_strobe),
        .addr_hit      (addr_hit),
        .data_strobe   (data_strobe),
        .pkt_valid     (pkt_valid),
        .wait_strobe   (wait_strobe),
        .resume_strobe (resume_strobe),
        .chk_strobe    (chk_strobe),
        .buf_full      (buf_full),
        .op            (op)
    );

    pbr_datapath #(.DATA_W(DATA_W)) u_datapath (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .din   (din),
        .dout  (dout)
    );

    pbr_parity #(.DATA_W(DATA_W)) u_parity (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .din      (din),
        .par_done (par_done),
        .par_err  (par_err)
    );
endmodule

// File: rtl/pkt_byte_reg_checker.sv
// Port-level properties of the packet byte register, bound to the top.
module pkt_byte_reg_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] din,
    input logic              pkt_valid,
    input logic              hdr_strobe,
    input logic              addr_hit,
    input logic              data_strobe,
    input logic              wait_strobe,
    input logic              resume_strobe,
    input logic              chk_strobe,
    input logic              buf_full,
    input logic [DATA_W-1:0] dout,
    input logic              par_done,
    input logic              par_err
);
    logic hdr_go;
    assign hdr_go = hdr_strobe && addr_hit;

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (dout == '0 && !par_done && !par_err));

    assert_hdr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_go |=> (dout == $past(din) && !par_err));

    assert_no_valid_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_strobe && !pkt_valid && !hdr_go && !chk_strobe && !resume_strobe && !wait_strobe)
        |=> $stable(dout));

    assert_stall_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_strobe && buf_full && !hdr_go && !chk_strobe && !resume_strobe)
        |=> $stable(dout));

    assert_done_after_chk_R9: assert property (@(posedge clk) disable iff (!rst_n)
        par_done |-> $past(chk_strobe));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_strobe && !hdr_go) |=> (par_done && dout == $past(din)));

    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (par_err && !hdr_go) |=> par_err);
endmodule

bind pkt_byte_reg pkt_byte_reg_checker #(.DATA_W(DATA_W)) u_checker (.*);

// File: tb/pkt_byte_reg_bench.sv
`timescale 1ns/1ps
module pkt_byte_reg_bench;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [DW-1:0] din;
    logic          pkt_valid, hdr_strobe, addr_hit, data_strobe;
    logic          wait_strobe, resume_strobe, chk_strobe, buf_full;
    logic [DW-1:0] dout;
    logic          par_done, par_err;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] exp_dout;
    logic          exp_err;
    logic [DW-1:0] pay [64];

    always #2.5 clk = ~clk;

    pkt_byte_reg #(.DATA_W(DW)) u_pkt_byte_reg (
        .clk(clk), .rst_n(rst_n), .din(din), .pkt_valid(pkt_valid),
        .hdr_strobe(hdr_strobe), .addr_hit(addr_hit), .data_strobe(data_strobe),
        .wait_strobe(wait_strobe), .resume_strobe(resume_strobe),
        .chk_strobe(chk_strobe), .buf_full(buf_full),
        .dout(dout), .par_done(par_done), .par_err(par_err)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic logic [DW-1:0] xor_sum(input logic [DW-1:0] h, input int n);
        logic [DW-1:0] s = h;
        for (int i = 0; i < n; i++) s = s ^ pay[i];
        return s;
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_in();
        pkt_valid = 0; hdr_strobe = 0; addr_hit = 0; data_strobe = 0;
        wait_strobe = 0; resume_strobe = 0; chk_strobe = 0; buf_full = 0;
    endtask

    // One rising edge, then settle at the falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send_hdr(input logic [DW-1:0] b);
        idle_in(); din = b; hdr_strobe = 1; addr_hit = 1; step();
        exp_dout = b; exp_err = 0;
        chk("R2 header dout", dout, exp_dout);
        chk("R2 header clears err", {7'd0, par_err}, 8'd0);
    endtask

    task automatic send_pay(input logic [DW-1:0] b, input int stall);
        idle_in(); din = b; data_strobe = 1; pkt_valid = 1;
        if (stall > 0) begin
            buf_full = 1; step();
            chk("R6 stalled byte not passed", dout, exp_dout);
            for (int k = 0; k < stall; k++) begin
                idle_in(); wait_strobe = 1; buf_full = 1; din = ~b; step();
                chk("R7 wait keeps dout", dout, exp_dout);
            end
            idle_in(); resume_strobe = 1; din = ~b; step();
            exp_dout = b;
            chk("R8 replay held byte", dout, exp_dout);
        end else begin
            step();
            exp_dout = b;
            chk("R4 payload dout", dout, exp_dout);
        end
    endtask

    task automatic send_chk(input logic [DW-1:0] b, input logic [DW-1:0] sum);
        idle_in(); din = b; chk_strobe = 1; step();
        exp_dout = b;
        exp_err = exp_err | (b != sum);
        chk("R9 check byte dout", dout, exp_dout);
        chk("R9 done pulse high", {7'd0, par_done}, 8'd1);
        chk("R10 parity flag", {7'd0, par_err}, {7'd0, exp_err});
        idle_in(); step();
        chk("R9 done pulse one cycle", {7'd0, par_done}, 8'd0);
        chk("R11 flag held", {7'd0, par_err}, {7'd0, exp_err});
    endtask

    task automatic run_packet(input int len, input int stall_pct, input logic corrupt);
        logic [DW-1:0] h;
        logic [DW-1:0] s;
        h = DW'($urandom);
        for (int i = 0; i < len; i++) pay[i] = DW'($urandom);
        send_hdr(h);
        for (int i = 0; i < len; i++)
            send_pay(pay[i], (($urandom % 100) < stall_pct) ? int'(1 + $urandom % 3) : 0);
        s = xor_sum(h, len);
        send_chk(corrupt ? (s ^ 8'h10) : s, s);
    endtask

    initial begin
        void'($urandom(32'd1234));
        idle_in(); din = 8'hA5; rst_n = 0;
        step(); step();
        exp_dout = 0; exp_err = 0;
        chk("R1 reset dout", dout, 8'h00);
        chk("R1 reset done", {7'd0, par_done}, 8'd0);
        chk("R1 reset err", {7'd0, par_err}, 8'd0);
        rst_n = 1;

        // Header strobe without address hit is ignored
        send_hdr(8'h3C);
        idle_in(); din = 8'hFF; hdr_strobe = 1; step();
        chk("R3 header without hit ignored", dout, exp_dout);

        // Payload strobe without valid data is ignored, parity unaffected
        idle_in(); din = 8'h81; data_strobe = 1; step();
        chk("R5 unqualified payload ignored", dout, exp_dout);
        pay[0] = 8'h12; send_pay(8'h12, 0);
        send_chk(8'h3C ^ 8'h12, 8'h3C ^ 8'h12);

        // Priority: header beats check strobe
        idle_in(); din = 8'h5A; hdr_strobe = 1; addr_hit = 1; chk_strobe = 1; step();
        exp_dout = 8'h5A; exp_err = 0;
        chk("R12 header wins", dout, exp_dout);
        chk("R12 no done on header", {7'd0, par_done}, 8'd0);
        // Priority: resume beats payload (held byte still 0 after reset path? use a stall)
        idle_in(); din = 8'h77; data_strobe = 1; pkt_valid = 1; buf_full = 1; step();
        idle_in(); din = 8'h99; resume_strobe = 1; data_strobe = 1; pkt_valid = 1; step();
        exp_dout = 8'h77;
        chk("R12 resume beats payload", dout, exp_dout);
        send_chk(8'h5A ^ 8'h77, 8'h5A ^ 8'h77);

        // Bad check byte: flag sticks through idle and payload, clears on header
        run_packet(3, 0, 1'b1);
        pay[0] = 8'h01; send_pay(8'h01, 0);
        chk("R11 flag sticky over payload", {7'd0, par_err}, 8'd1);
        send_hdr(8'h20);

        // Longest packet with stalls
        run_packet(63, 20, 1'b0);
        run_packet(1, 0, 1'b0);

        // Random packets
        for (int p = 0; p < 40; p++)
            run_packet(int'(1 + $urandom % 12), 25, ($urandom % 4) == 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule